// File: doc/BRIEF.md
# TFT Panel Timing Generator

This block produces the raster control signals for a TFT display panel: a divided pixel clock, horizontal and vertical sync pulses, a data-enable strobe that frames the visible area, and a one-pixel line-end marker. Every interval comes from a programmable field. Each field holds the interval length minus one: sync width, back porch, active size and front porch, for both axes. The pixel clock divider field works the same way. The block also drives the current pixel column and line row, so that a separate fetch path can deliver the matching pixel data.

Inside each line the segments run in a fixed order: sync pulse, back porch, active pixels, front porch. The frame uses the same order, counted in lines. The field values are captured only while the block is disabled or at the first pixel of a new frame. A register write in the middle of a frame therefore takes effect from the next frame. A separate output drives the panel power switch. It can be slaved to the video enable input, and its polarity can be inverted.

Top module: `lcd_tft_timer`

## Requirements
- R1: With `clk_div_m1` = D, `pix_clk` has a period of 2×(D+1) bus clocks. After the first rising edge that samples `vid_en` high, it is low for D+1 cycles and then high for D+1 cycles. D = 0 is legal. Positions advance on the falling transition of `pix_clk`.
- R2: A line is (HS+1)+(HB+1)+(HA+1)+(HF+1) pixel periods long, where HS, HB, HA and HF are the horizontal field values. `hsync` is high (default polarity) during the first HS+1 periods of each line.
- R3: A frame is (VS+1)+(VB+1)+(VA+1)+(VF+1) lines long. `vsync` is high during the first VS+1 lines of the frame and rises together with `hsync` at the start of a line.
- R4: `den` is high only in pixel periods where the column lies in the horizontal active segment (after sync and back porch, HA+1 pixels long) and the line lies in the vertical active segment. `den` never coincides with a sync pulse.
- R5: `pix_x` gives the column index from 0 at the first active pixel, and `line_y` gives the row index from 0 at the first active line. Each reads 0 outside its active segment.
- R6: `line_end` is high for exactly the last pixel period of each line's front porch and never overlaps `hsync`.
- R7: All fields, including the divider, are taken from the inputs only while disabled or at the pixel edge that starts a new frame. Changes made mid-frame have no effect until the next frame begins.
- R8: One bus clock after `vid_en` is sampled low, `pix_clk`, `hsync`, `vsync`, `den`, `line_end`, `pix_x` and `line_y` are all at their inactive level (0). On re-enable the frame restarts at the first pixel of vertical and horizontal sync.
- R9: `pwr_out` is registered. When `pwr_ctl_en` is 1 it equals `vid_en` XOR `pwr_invert` one cycle later. When `pwr_ctl_en` is 0 it equals `pwr_invert` one cycle later.
- R10: During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vid_en | input | 1 | Video enable; low holds the raster at frame start |
| pwr_ctl_en | input | 1 | Slave panel power to `vid_en` |
| pwr_invert | input | 1 | Invert panel power polarity |
| clk_div_m1 | input | DIV_W | Pixel clock divider field |
| h_sync_m1 | input | H_W | Horizontal sync width minus one |
| h_back_m1 | input | H_W | Horizontal back porch minus one |
| h_act_m1 | input | H_W | Active width minus one |
| h_front_m1 | input | H_W | Horizontal front porch minus one |
| v_sync_m1 | input | V_W | Vertical sync width minus one (lines) |
| v_back_m1 | input | V_W | Vertical back porch minus one |
| v_act_m1 | input | V_W | Active height minus one |
| v_front_m1 | input | V_W | Vertical front porch minus one |
| pix_clk | output | 1 | Pixel clock to panel |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| den | output | 1 | Data enable |
| line_end | output | 1 | Last pixel of each line |
| pwr_out | output | 1 | Panel power control |
| pix_x | output | H_W | Active column index |
| line_y | output | V_W | Active row index |

## Verification
A wrong segment state or position count in the horizontal counter appears within a single pixel period. It shows as a displaced `hsync`, `den` or `line_end` edge or a wrong `pix_x`. A vertical fault appears at the next line boundary through `vsync`, `den` or `line_y`. A shadow register captured at the wrong moment shows up as soon as a mid-frame field change alters a pulse width before the frame ends. A divider fault shows within one pixel period on `pix_clk`. The bench keeps a cycle-level reference of the raster and compares every output on every bus cycle, so each such fault is seen in the cycle it first becomes visible.

// File: rtl/lcdt_pkg.sv
`timescale 1ns/1ps
package lcdt_pkg;

   // Segment order within a line or a frame; the order is behaviour.
   typedef enum logic [1:0] {
      SEG_SYNC  = 2'd0,
      SEG_BACK  = 2'd1,
      SEG_ACT   = 2'd2,
      SEG_FRONT = 2'd3
   } seg_t;

   function automatic seg_t seg_after(seg_t s);
      case (s)
         SEG_SYNC:  return SEG_BACK;
         SEG_BACK:  return SEG_ACT;
         SEG_ACT:   return SEG_FRONT;
         default:   return SEG_SYNC;
      endcase
   endfunction

endpackage

// File: rtl/lcdt_pixdiv.sv
`timescale 1ns/1ps
// Pixel clock divider: half period of (div+1) bus clocks.
module lcdt_pixdiv #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic [DW-1:0] div,
   output logic          pclk,
   output logic          tick
);
   logic [DW-1:0] cnt_q;
   logic          half_q;
   logic          at_end;

   assign at_end = (cnt_q == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         half_q <= 1'b0;
      end else if (clr) begin
         cnt_q  <= '0;
         half_q <= 1'b0;
      end else if (at_end) begin
         cnt_q  <= '0;
         half_q <= ~half_q;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   assign pclk = half_q;
   // Advance strobe coincides with the falling transition of pclk.
   assign tick = at_end & half_q;
endmodule

// File: rtl/lcdt_axis.sv
`timescale 1ns/1ps
// One raster axis: walks sync, back porch, active, front porch.
module lcdt_axis
   import lcdt_pkg::*;
#(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         step,
   input  logic [W-1:0] len_sync,
   input  logic [W-1:0] len_back,
   input  logic [W-1:0] len_act,
   input  logic [W-1:0] len_front,
   output seg_t         seg,
   output logic [W-1:0] pos,
   output logic         last
);
   seg_t         seg_q;
   logic [W-1:0] pos_q;
   logic [W-1:0] seg_len;
   logic         seg_done;

   always_comb begin
      case (seg_q)
         SEG_SYNC:  seg_len = len_sync;
         SEG_BACK:  seg_len = len_back;
         SEG_ACT:   seg_len = len_act;
         default:   seg_len = len_front;
      endcase
   end

   assign seg_done = (pos_q == seg_len);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seg_q <= SEG_SYNC;
         pos_q <= '0;
      end else if (clr) begin
         seg_q <= SEG_SYNC;
         pos_q <= '0;
      end else if (step) begin
         if (seg_done) begin
            seg_q <= seg_after(seg_q);
            pos_q <= '0;
         end else begin
            pos_q <= pos_q + 1'b1;
         end
      end
   end

   assign seg  = seg_q;
   assign pos  = pos_q;
   assign last = (seg_q == SEG_FRONT) && seg_done;
endmodule

// File: rtl/lcd_tft_timer.sv
`timescale 1ns/1ps
module lcd_tft_timer
   import lcdt_pkg::*;
#(
   parameter int H_W      = 10,
   parameter int V_W      = 10,
   parameter int DIV_W    = 8,
   parameter bit SYNC_POL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vid_en,
   input  logic             pwr_ctl_en,
   input  logic             pwr_invert,
   input  logic [DIV_W-1:0] clk_div_m1,
   input  logic [H_W-1:0]   h_sync_m1,
   input  logic [H_W-1:0]   h_back_m1,
   input  logic [H_W-1:0]   h_act_m1,
   input  logic [H_W-1:0]   h_front_m1,
   input  logic [V_W-1:0]   v_sync_m1,
   input  logic [V_W-1:0]   v_back_m1,
   input  logic [V_W-1:0]   v_act_m1,
   input  logic [V_W-1:0]   v_front_m1,
   output logic             pix_clk,
   output logic             hsync,
   output logic             vsync,
   output logic             den,
   output logic             line_end,
   output logic             pwr_out,
   output logic [H_W-1:0]   pix_x,
   output logic [V_W-1:0]   line_y
);
   initial begin
      assert (H_W >= 2 && H_W <= 16) else $error("H_W out of range");
      assert (V_W >= 2 && V_W <= 16) else $error("V_W out of range");
      assert (DIV_W >= 1 && DIV_W <= 16) else $error("DIV_W out of range");
   end

   logic             run_q;
   logic             clr;
   logic             pclk, tick;
   logic             h_last, v_last, v_step, frame_wrap, take_cfg;
   seg_t             h_seg, v_seg;
   logic [H_W-1:0]   h_pos;
   logic [V_W-1:0]   v_pos;
   logic             pwr_q;

   // Shadow copies of the programmable fields.
   logic [DIV_W-1:0] sh_div;
   logic [H_W-1:0]   sh_hs, sh_hb, sh_ha, sh_hf;
   logic [V_W-1:0]   sh_vs, sh_vb, sh_va, sh_vf;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_q <= 1'b0;
      else        run_q <= vid_en;
   end

   assign clr        = ~run_q;
   assign v_step     = tick & h_last;
   assign frame_wrap = v_step & v_last;
   assign take_cfg   = clr | frame_wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_div <= '0;
         sh_hs <= '0; sh_hb <= '0; sh_ha <= '0; sh_hf <= '0;
         sh_vs <= '0; sh_vb <= '0; sh_va <= '0; sh_vf <= '0;
      end else if (take_cfg) begin
         sh_div <= clk_div_m1;
         sh_hs <= h_sync_m1; sh_hb <= h_back_m1;
         sh_ha <= h_act_m1;  sh_hf <= h_front_m1;
         sh_vs <= v_sync_m1; sh_vb <= v_back_m1;
         sh_va <= v_act_m1;  sh_vf <= v_front_m1;
      end
   end

   lcdt_pixdiv #(.DW(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .clr(clr), .div(sh_div),
      .pclk(pclk), .tick(tick)
   );

   lcdt_axis #(.W(H_W)) u_h (
      .clk(clk), .rst_n(rst_n), .clr(clr), .step(tick),
      .len_sync(sh_hs), .len_back(sh_hb), .len_act(sh_ha), .len_front(sh_hf),
      .seg(h_seg), .pos(h_pos), .last(h_last)
   );

   lcdt_axis #(.W(V_W)) u_v (
      .clk(clk), .rst_n(rst_n), .clr(clr), .step(v_step),
      .len_sync(sh_vs), .len_back(sh_vb), .len_act(sh_va), .len_front(sh_vf),
      .seg(v_seg), .pos(v_pos), .last(v_last)
   );

   logic hs_on, vs_on, h_in, v_in;
   assign hs_on = run_q && (h_seg == SEG_SYNC);
   assign vs_on = run_q && (v_seg == SEG_SYNC);
   assign h_in  = run_q && (h_seg == SEG_ACT);
   assign v_in  = run_q && (v_seg == SEG_ACT);

   generate
      if (SYNC_POL) begin : g_sync_high
         assign hsync = hs_on;
         assign vsync = vs_on;
      end else begin : g_sync_low
         assign hsync = ~hs_on;
         assign vsync = ~vs_on;
      end
   endgenerate

   assign pix_clk  = run_q & pclk;
   assign den      = h_in & v_in;
   assign line_end = run_q & h_last;
   assign pix_x    = h_in ? h_pos : '0;
   assign line_y   = v_in ? v_pos : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pwr_q <= 1'b0;
      else if (pwr_ctl_en) pwr_q <= vid_en ^ pwr_invert;
      else                 pwr_q <= pwr_invert;
   end
   assign pwr_out = pwr_q;
endmodule

// File: rtl/lcdt_chk.sv
`timescale 1ns/1ps
// Property checker; written for the default active-high sync polarity.
module lcdt_chk (
   input logic clk,
   input logic rst_n,
   input logic vid_en,
   input logic pwr_ctl_en,
   input logic pwr_invert,
   input logic pix_clk,
   input logic hsync,
   input logic vsync,
   input logic den,
   input logic line_end,
   input logic pwr_out
);
   // R8
   quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !vid_en |=> (!pix_clk && !den && !line_end && !hsync && !vsync));

   // R4
   den_outside_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      den |-> (!hsync && !vsync && !line_end));

   // R6
   line_end_no_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_end |-> !hsync);

   // R3
   vsync_at_line_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vsync) |-> hsync);

   // R1
   hsync_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hsync) |-> !pix_clk);

   // R9
   pwr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_ctl_en |=> (pwr_out == ($past(vid_en) ^ $past(pwr_invert))));

   // R9
   pwr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_ctl_en |=> (pwr_out == $past(pwr_invert)));
endmodule

bind lcd_tft_timer lcdt_chk u_chk (
   .clk(clk), .rst_n(rst_n), .vid_en(vid_en), .pwr_ctl_en(pwr_ctl_en),
   .pwr_invert(pwr_invert), .pix_clk(pix_clk), .hsync(hsync), .vsync(vsync),
   .den(den), .line_end(line_end), .pwr_out(pwr_out)
);

// File: tb/sim_lcd_tft_timer.sv
`timescale 1ns/1ps
module sim_lcd_tft_timer;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic       rst_n = 1'b0;
   logic       vid_en = 1'b0, pwr_ctl_en = 1'b0, pwr_invert = 1'b0;
   logic [7:0] cfg_div = '0;
   logic [9:0] cfg_hs = '0, cfg_hb = '0, cfg_ha = '0, cfg_hf = '0;
   logic [9:0] cfg_vs = '0, cfg_vb = '0, cfg_va = '0, cfg_vf = '0;

   logic       pix_clk, hsync, vsync, den, line_end, pwr_out;
   logic [9:0] pix_x, line_y;

   lcd_tft_timer u0 (
      .clk(clk), .rst_n(rst_n), .vid_en(vid_en), .pwr_ctl_en(pwr_ctl_en),
      .pwr_invert(pwr_invert), .clk_div_m1(cfg_div),
      .h_sync_m1(cfg_hs), .h_back_m1(cfg_hb), .h_act_m1(cfg_ha), .h_front_m1(cfg_hf),
      .v_sync_m1(cfg_vs), .v_back_m1(cfg_vb), .v_act_m1(cfg_va), .v_front_m1(cfg_vf),
      .pix_clk(pix_clk), .hsync(hsync), .vsync(vsync), .den(den),
      .line_end(line_end), .pwr_out(pwr_out), .pix_x(pix_x), .line_y(line_y)
   );

   typedef struct packed {
      logic       pc, hs, vs, de, le, pw;
      logic [9:0] px, ly;
   } exp_t;

   exp_t sb[$];
   int   n_cmp = 0, n_bad = 0;
   bit   finished = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
      end
   endtask

   // Reference raster: pixel index within line and line within frame.
   bit m_run = 0, m_pw = 0;
   int m_sub = 0, m_x = 0, m_y = 0;
   int s_div, s_hs, s_hb, s_ha, s_hf, s_vs, s_vb, s_va, s_vf;

   task automatic grab_cfg();
      s_div = cfg_div; s_hs = cfg_hs; s_hb = cfg_hb; s_ha = cfg_ha; s_hf = cfg_hf;
      s_vs = cfg_vs; s_vb = cfg_vb; s_va = cfg_va; s_vf = cfg_vf;
   endtask

   always @(posedge clk) begin
      exp_t e;
      int per, hl, vl, h0, v0;
      bit hin, vin;
      if (!rst_n) begin
         m_run = 0; m_pw = 0; m_sub = 0; m_x = 0; m_y = 0;
         grab_cfg();
      end else begin
         if (m_run) begin
            per = 2 * (s_div + 1);
            hl  = s_hs + s_hb + s_ha + s_hf + 4;
            vl  = s_vs + s_vb + s_va + s_vf + 4;
            if (m_sub == per - 1) begin
               m_sub = 0;
               if (m_x == hl - 1) begin
                  m_x = 0;
                  if (m_y == vl - 1) begin
                     m_y = 0;
                     grab_cfg();             // R7: new fields only at frame start
                  end else m_y++;
               end else m_x++;
            end else m_sub++;
         end else begin
            m_sub = 0; m_x = 0; m_y = 0;    // R8: restart at sync
            grab_cfg();
         end
         m_run = vid_en;
         m_pw  = pwr_ctl_en ? (vid_en ^ pwr_invert) : pwr_invert;
      end
      e = '0;
      e.pw = m_pw;
      if (m_run) begin
         hl  = s_hs + s_hb + s_ha + s_hf + 4;
         h0  = s_hs + s_hb + 2;
         v0  = s_vs + s_vb + 2;
         hin = (m_x >= h0) && (m_x < h0 + s_ha + 1);
         vin = (m_y >= v0) && (m_y < v0 + s_va + 1);
         e.pc = (m_sub > s_div);
         e.hs = (m_x <= s_hs);
         e.vs = (m_y <= s_vs);
         e.de = hin && vin;
         e.le = (m_x == hl - 1);
         e.px = hin ? 10'(m_x - h0) : 10'd0;
         e.ly = vin ? 10'(m_y - v0) : 10'd0;
      end
      sb.push_back(e);
   end

   // Monitor: compare away from the active edge.
   always @(negedge clk) begin
      exp_t e;
      if (sb.size() > 0 && !finished) begin
         e = sb.pop_front();
         chk(pix_clk == e.pc,  "R1 pix_clk",   pix_clk,  e.pc);
         chk(hsync == e.hs,    "R2 hsync",     hsync,    e.hs);
         chk(vsync == e.vs,    "R3 vsync",     vsync,    e.vs);
         chk(den == e.de,      "R4 den",       den,      e.de);
         chk(pix_x == e.px,    "R5 pix_x",     pix_x,    e.px);
         chk(line_y == e.ly,   "R5 line_y",    line_y,   e.ly);
         chk(line_end == e.le, "R6 line_end",  line_end, e.le);
         chk(pwr_out == e.pw,  "R9 pwr_out",   pwr_out,  e.pw);
      end
   end

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #4_000_000;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired at %0t: actual 0 expected 1", $time);
      finish_run();
   end

   initial begin
      cycles(4);
      // R10: outputs idle in reset
      chk({pix_clk, hsync, vsync, den, line_end, pwr_out} == 6'b0, "R10 reset outputs",
          {pix_clk, hsync, vsync, den, line_end, pwr_out}, 0);
      chk(pix_x == 0 && line_y == 0, "R10 reset position", pix_x + line_y, 0);
      rst_n = 1'b1;
      cycles(3);

      // Config A, divider 0
      cfg_div = 8'd0;
      cfg_hs = 10'd1; cfg_hb = 10'd1; cfg_ha = 10'd7; cfg_hf = 10'd2;
      cfg_vs = 10'd0; cfg_vb = 10'd1; cfg_va = 10'd3; cfg_vf = 10'd0;
      pwr_ctl_en = 1'b1;
      cycles(2);
      vid_en = 1'b1;
      cycles(300);

      // R7: change fields mid-frame; take effect at next frame
      cfg_div = 8'd2;
      cfg_hs = 10'd0; cfg_hb = 10'd0; cfg_ha = 10'd4; cfg_hf = 10'd0;
      cfg_vs = 10'd1; cfg_vb = 10'd0; cfg_va = 10'd2; cfg_vf = 10'd1;
      cycles(1000);

      // R8 and R9: disable mid-frame, vary power controls
      vid_en = 1'b0;
      cycles(4);
      pwr_invert = 1'b1;
      cycles(4);
      pwr_ctl_en = 1'b0;
      cycles(4);
      pwr_ctl_en = 1'b1;

      // Minimum intervals, divider 1
      cfg_div = 8'd1;
      cfg_hs = 10'd0; cfg_hb = 10'd0; cfg_ha = 10'd0; cfg_hf = 10'd0;
      cfg_vs = 10'd0; cfg_vb = 10'd0; cfg_va = 10'd0; cfg_vf = 10'd0;
      cycles(2);
      vid_en = 1'b1;
      cycles(300);

      // Wider active area with larger divider, then stop mid-line
      cfg_div = 8'd3;
      cfg_hs = 10'd2; cfg_hb = 10'd0; cfg_ha = 10'd9; cfg_hf = 10'd1;
      cfg_vs = 10'd2; cfg_vb = 10'd2; cfg_va = 10'd4; cfg_vf = 10'd2;
      cycles(1500);
      vid_en = 1'b0;
      cycles(10);
      finish_run();
   end
endmodule